// File: doc/BRIEF.md
# Character-Cell Raster Position Generator

This block sits between the video timing and a text overlay's memories. It counts dot-clock cycles since the last horizontal sync pulse and lines since the last vertical sync pulse. It places a text window of 12 rows by 24 columns at a programmable offset from those pulses. For every pixel it reports whether that pixel falls inside the window. When it does, the block also reports which character cell the pixel belongs to and which dot of the 12-wide by 18-tall glyph cell it addresses.

Each text row can be magnified 1x, 2x or 3x. A magnified row is taller, so the vertical positions of all rows below it move down. Its cells are also wider, so that row's window is wider. Four rows carry their own size code. The remaining rows take the code of the closest programmable row above them.

The outputs feed the display-memory read port (row and column packed into one address) and the glyph store (dot row and dot column). Every result is registered once, on the dot-clock enable.

Top module: `osd_raster_pos`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: Sync pulses are sampled only on cycles with `dot_en` high, and a leading (rising) edge is a sample of 1 after a sample of 0. The horizontal position counts enabled cycles since the last `hsync` leading edge, starting at 0 on the cycle after the edge. The line number counts `hsync` leading edges since the last `vsync` leading edge. When both edges land on the same enabled cycle, the line number becomes 0.
- R3: The window's first line is line `v_offset`. The window's height is the sum of 18·N over all 12 rows, where N is each row's magnification. Rows stack top to bottom with no gap.
- R4: On a line inside the window, the pixel at horizontal position `h_offset` is the first one inside. The window width on that line is 24·12·N dots, where N is the size of the current row.
- R5: Size codes: 2'b01 gives double size, 2'b10 gives triple size, and 2'b00 and 2'b11 both give normal size. `size_a` sets row 0 and `size_b` sets rows 1 to 7. `size_c` sets rows 8 and 9, and `size_d` sets rows 10 and 11 (all row numbers counted from 0).
- R6: Inside the window, take x as the offset from `h_offset` and y as the offset from the current row's first line. Then `char_col` = x / (12N), `dot_x` = (x mod 12N) / N, and `dot_y` = y / N.
- R7: Outside the window, `in_window` is 0 and `char_row`, `char_col`, `dot_x`, `dot_y` and `mem_addr` are all 0.
- R8: `mem_addr` carries the character row in bits 8:5 and the character column in bits 4:0.
- R9: On a cycle with `dot_en` low, no counter, sync sample or output changes.
- R10: The outputs after an enabled clock edge describe the position the counters held just before that edge, which gives one enabled cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dot_en | input | 1 | Dot-clock enable, one pixel per enabled cycle |
| hsync | input | 1 | Horizontal sync, leading edge is rising |
| vsync | input | 1 | Vertical sync, leading edge is rising |
| v_offset | input | 6 | Window start line after the vertical sync |
| h_offset | input | 6 | Window start dot after the horizontal sync |
| size_a | input | 2 | Size code for row 0 |
| size_b | input | 2 | Size code for rows 1 to 7 |
| size_c | input | 2 | Size code for rows 8 and 9 |
| size_d | input | 2 | Size code for rows 10 and 11 |
| in_window | output | 1 | Pixel lies inside the text window |
| char_row | output | 4 | Text row, 0 to 11 |
| char_col | output | 5 | Text column, 0 to 23 |
| dot_x | output | 4 | Glyph dot column, 0 to 11 |
| dot_y | output | 5 | Glyph dot row, 0 to 17 |
| mem_addr | output | 9 | Display-memory read address {row, column} |

## Verification
Two cases can fall on the same enabled cycle. In the first, a horizontal and a vertical leading edge coincide and the line-number reset has to win over the line increment. In the second, the dot-enable drops on a cycle where a sync edge or a window boundary would otherwise act. One frame raises both syncs on the same tick, and the enable is withheld on random cycles throughout. A bench model advances its own counters by the stated rules and predicts every output. It also checks that outputs sampled after a disabled cycle have not moved.

// File: rtl/osd_pos_pkg.sv
package osd_pos_pkg;

  typedef logic [1:0] size_code_t;

  // First row (0-based) governed by each size input; rows in between inherit
  localparam int unsigned SZ_ROW_A = 0;
  localparam int unsigned SZ_ROW_B = 1;
  localparam int unsigned SZ_ROW_C = 8;
  localparam int unsigned SZ_ROW_D = 10;

  // Size code to magnification factor 1..3
  function automatic logic [1:0] decode_mult(input size_code_t code);
    case (code)
      2'b01:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/osd_sync_counter.sv
module osd_sync_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sync_lvl,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             lead
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sync_q;
  logic             sync_d;
  logic [CNT_W-1:0] cnt_d;

  assign lead = en & sync_lvl & ~sync_q;

  always_comb begin
    sync_d = sync_q;
    cnt_d  = cnt;
    if (en) begin
      sync_d = sync_lvl;
      if (lead) begin
        cnt_d = '0;
      end else if (step && (cnt != CNT_MAX)) begin
        cnt_d = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      cnt    <= '0;
    end else begin
      sync_q <= sync_d;
      cnt    <= cnt_d;
    end
  end

endmodule

// File: rtl/osd_row_map.sv
module osd_row_map #(
  parameter int unsigned ROWS    = 12,
  parameter int unsigned CELL_H  = 18,
  parameter int unsigned VCNT_W  = 10,
  parameter int unsigned START_W = 6,
  localparam int unsigned RW     = $clog2(ROWS),
  localparam int unsigned DYW    = $clog2(CELL_H)
) (
  input  logic [VCNT_W-1:0]       vcnt,
  input  logic [START_W-1:0]      vstart,
  input  logic [ROWS-1:0][1:0]    row_mult,
  output logic                    v_in,
  output logic [RW-1:0]           row,
  output logic [1:0]              mult,
  output logic [DYW-1:0]          dot_y
);

  logic [VCNT_W-1:0] bnd [ROWS+1];
  logic [VCNT_W-1:0] y;
  logic [VCNT_W-1:0] off;
  logic [VCNT_W-1:0] dy;
  logic              above;

  // Accumulated row boundaries, relative to the window's first line
  assign bnd[0] = '0;
  for (genvar r = 0; r < ROWS; r++) begin : g_bnd
    assign bnd[r+1] = bnd[r] + VCNT_W'(CELL_H * row_mult[r]);
  end

  assign above = (vcnt >= VCNT_W'(vstart));
  assign y     = vcnt - VCNT_W'(vstart);

  always_comb begin
    v_in = above && (y < bnd[ROWS]);
    row  = '0;
    mult = 2'd1;
    off  = '0;
    for (int r = 0; r < ROWS; r++) begin
      if ((y >= bnd[r]) && (y < bnd[r+1])) begin
        row  = RW'(r);
        mult = row_mult[r];
        off  = y - bnd[r];
      end
    end
    case (mult)
      2'd2:    dy = off >> 1;
      2'd3:    dy = off / VCNT_W'(3);
      default: dy = off;
    endcase
    dot_y = DYW'(dy);
  end

endmodule

// File: rtl/osd_col_map.sv
module osd_col_map #(
  parameter int unsigned COLS    = 24,
  parameter int unsigned CELL_W  = 12,
  parameter int unsigned HCNT_W  = 11,
  parameter int unsigned START_W = 6,
  localparam int unsigned CW     = $clog2(COLS),
  localparam int unsigned DXW    = $clog2(CELL_W)
) (
  input  logic [HCNT_W-1:0]  hcnt,
  input  logic [START_W-1:0] hstart,
  input  logic [1:0]         mult,
  output logic               h_in,
  output logic [CW-1:0]      col,
  output logic [DXW-1:0]     dot_x
);

  localparam logic [HCNT_W-1:0] PITCH1 = HCNT_W'(CELL_W);
  localparam logic [HCNT_W-1:0] PITCH2 = HCNT_W'(2 * CELL_W);
  localparam logic [HCNT_W-1:0] PITCH3 = HCNT_W'(3 * CELL_W);
  localparam logic [HCNT_W-1:0] NCOLS  = HCNT_W'(COLS);

  logic [HCNT_W-1:0] x;
  logic [HCNT_W-1:0] pitch;
  logic [HCNT_W-1:0] q;
  logic [HCNT_W-1:0] rem;
  logic [HCNT_W-1:0] dx;
  logic              above;

  assign above = (hcnt >= HCNT_W'(hstart));
  assign x     = hcnt - HCNT_W'(hstart);

  always_comb begin
    case (mult)
      2'd2: begin
        pitch = PITCH2;
        q     = x / PITCH2;
      end
      2'd3: begin
        pitch = PITCH3;
        q     = x / PITCH3;
      end
      default: begin
        pitch = PITCH1;
        q     = x / PITCH1;
      end
    endcase
    rem = x - q * pitch;
    case (mult)
      2'd2:    dx = rem >> 1;
      2'd3:    dx = rem / HCNT_W'(3);
      default: dx = rem;
    endcase
    h_in  = above && (x < NCOLS * pitch);
    col   = CW'(q);
    dot_x = DXW'(dx);
  end

endmodule

// File: rtl/osd_raster_pos.sv
module osd_raster_pos
  import osd_pos_pkg::*;
#(
  parameter int unsigned ROWS    = 12,
  parameter int unsigned COLS    = 24,
  parameter int unsigned CELL_W  = 12,
  parameter int unsigned CELL_H  = 18,
  parameter int unsigned START_W = 6,
  parameter int unsigned HCNT_W  = 11,
  parameter int unsigned VCNT_W  = 10,
  localparam int unsigned RW     = $clog2(ROWS),
  localparam int unsigned CW     = $clog2(COLS),
  localparam int unsigned DXW    = $clog2(CELL_W),
  localparam int unsigned DYW    = $clog2(CELL_H)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dot_en,
  input  logic               hsync,
  input  logic               vsync,
  input  logic [START_W-1:0] v_offset,
  input  logic [START_W-1:0] h_offset,
  input  logic [1:0]         size_a,
  input  logic [1:0]         size_b,
  input  logic [1:0]         size_c,
  input  logic [1:0]         size_d,
  output logic               in_window,
  output logic [RW-1:0]      char_row,
  output logic [CW-1:0]      char_col,
  output logic [DXW-1:0]     dot_x,
  output logic [DYW-1:0]     dot_y,
  output logic [RW+CW-1:0]   mem_addr
);

  logic [HCNT_W-1:0]   hcnt;
  logic [VCNT_W-1:0]   vcnt;
  logic                h_lead;
  logic                v_lead;
  logic [ROWS-1:0][1:0] row_mult;
  logic                v_in;
  logic                h_in;
  logic [RW-1:0]       row_w;
  logic [1:0]          mult_w;
  logic [DYW-1:0]      dy_w;
  logic [CW-1:0]       col_w;
  logic [DXW-1:0]      dx_w;

  logic                in_window_d;
  logic [RW-1:0]       char_row_d;
  logic [CW-1:0]       char_col_d;
  logic [DXW-1:0]      dot_x_d;
  logic [DYW-1:0]      dot_y_d;
  logic [RW+CW-1:0]    mem_addr_d;

  // Per-row magnification with inheritance from the nearest governed row above
  for (genvar r = 0; r < ROWS; r++) begin : g_rowsz
    if (r >= SZ_ROW_D) begin : g_d
      assign row_mult[r] = decode_mult(size_d);
    end else if (r >= SZ_ROW_C) begin : g_c
      assign row_mult[r] = decode_mult(size_c);
    end else if (r >= SZ_ROW_B) begin : g_b
      assign row_mult[r] = decode_mult(size_b);
    end else begin : g_a
      assign row_mult[r] = decode_mult(size_a);
    end
  end

  osd_sync_counter #(.CNT_W(HCNT_W)) u_hcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (dot_en),
    .sync_lvl (hsync),
    .step     (1'b1),
    .cnt      (hcnt),
    .lead     (h_lead)
  );

  osd_sync_counter #(.CNT_W(VCNT_W)) u_vcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (dot_en),
    .sync_lvl (vsync),
    .step     (h_lead),
    .cnt      (vcnt),
    .lead     (v_lead)
  );

  osd_row_map #(
    .ROWS(ROWS), .CELL_H(CELL_H), .VCNT_W(VCNT_W), .START_W(START_W)
  ) u_rows (
    .vcnt     (vcnt),
    .vstart   (v_offset),
    .row_mult (row_mult),
    .v_in     (v_in),
    .row      (row_w),
    .mult     (mult_w),
    .dot_y    (dy_w)
  );

  osd_col_map #(
    .COLS(COLS), .CELL_W(CELL_W), .HCNT_W(HCNT_W), .START_W(START_W)
  ) u_cols (
    .hcnt   (hcnt),
    .hstart (h_offset),
    .mult   (mult_w),
    .h_in   (h_in),
    .col    (col_w),
    .dot_x  (dx_w)
  );

  always_comb begin
    in_window_d = in_window;
    char_row_d  = char_row;
    char_col_d  = char_col;
    dot_x_d     = dot_x;
    dot_y_d     = dot_y;
    mem_addr_d  = mem_addr;
    if (dot_en) begin
      if (v_in && h_in) begin
        in_window_d = 1'b1;
        char_row_d  = row_w;
        char_col_d  = col_w;
        dot_x_d     = dx_w;
        dot_y_d     = dy_w;
        mem_addr_d  = {row_w, col_w};
      end else begin
        in_window_d = 1'b0;
        char_row_d  = '0;
        char_col_d  = '0;
        dot_x_d     = '0;
        dot_y_d     = '0;
        mem_addr_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_window <= 1'b0;
      char_row  <= '0;
      char_col  <= '0;
      dot_x     <= '0;
      dot_y     <= '0;
      mem_addr  <= '0;
    end else begin
      in_window <= in_window_d;
      char_row  <= char_row_d;
      char_col  <= char_col_d;
      dot_x     <= dot_x_d;
      dot_y     <= dot_y_d;
      mem_addr  <= mem_addr_d;
    end
  end

endmodule

// File: rtl/osd_raster_pos_chk.sv
module osd_raster_pos_chk #(
  parameter int unsigned ROWS   = 12,
  parameter int unsigned COLS   = 24,
  parameter int unsigned CELL_W = 12,
  parameter int unsigned CELL_H = 18,
  localparam int unsigned RW    = $clog2(ROWS),
  localparam int unsigned CW    = $clog2(COLS),
  localparam int unsigned DXW   = $clog2(CELL_W),
  localparam int unsigned DYW   = $clog2(CELL_H)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dot_en,
  input logic             in_window,
  input logic [RW-1:0]    char_row,
  input logic [CW-1:0]    char_col,
  input logic [DXW-1:0]   dot_x,
  input logic [DYW-1:0]   dot_y,
  input logic [RW+CW-1:0] mem_addr
);

  // R9: a disabled cycle leaves every output unchanged
  assert_hold_on_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> $stable({in_window, char_row, char_col, dot_x, dot_y, mem_addr}));

  // R7: outside the window all coordinates read zero
  assert_zero_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |-> (char_row == '0 && char_col == '0 && dot_x == '0 &&
                    dot_y == '0 && mem_addr == '0));

  // R6: cell coordinates stay inside the glyph and the row
  assert_cell_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> (dot_x < DXW'(CELL_W) && dot_y < DYW'(CELL_H) &&
                   char_col < CW'(COLS)));

  // R5: the row index never exceeds the last text row
  assert_row_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> (char_row < RW'(ROWS)));

endmodule

bind osd_raster_pos osd_raster_pos_chk #(
  .ROWS(ROWS), .COLS(COLS), .CELL_W(CELL_W), .CELL_H(CELL_H)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dot_en    (dot_en),
  .in_window (in_window),
  .char_row  (char_row),
  .char_col  (char_col),
  .dot_x     (dot_x),
  .dot_y     (dot_y),
  .mem_addr  (mem_addr)
);

// File: tb/osd_raster_pos_bench.sv
module osd_raster_pos_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dot_en;
  logic       hsync;
  logic       vsync;
  logic [5:0] v_offset;
  logic [5:0] h_offset;
  logic [1:0] size_a, size_b, size_c, size_d;
  logic       in_window;
  logic [3:0] char_row;
  logic [4:0] char_col;
  logic [3:0] dot_x;
  logic [4:0] dot_y;
  logic [8:0] mem_addr;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  osd_raster_pos u_osd_raster_pos (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .hsync(hsync), .vsync(vsync),
    .v_offset(v_offset), .h_offset(h_offset),
    .size_a(size_a), .size_b(size_b), .size_c(size_c), .size_d(size_d),
    .in_window(in_window), .char_row(char_row), .char_col(char_col),
    .dot_x(dot_x), .dot_y(dot_y), .mem_addr(mem_addr)
  );

  typedef struct {
    bit inw;
    int row;
    int col;
    int dx;
    int dy;
  } pos_t;

  // R5: code decode and inheritance
  function automatic int mag(bit [1:0] c);
    if (c == 2'b01) return 2;
    if (c == 2'b10) return 3;
    return 1;
  endfunction

  function automatic int row_size(int r);
    if (r >= 10) return mag(size_d);
    if (r >= 8)  return mag(size_c);
    if (r >= 1)  return mag(size_b);
    return mag(size_a);
  endfunction

  function automatic int win_height();
    int s = 0;
    for (int r = 0; r < 12; r++) s += 18 * row_size(r);
    return s;
  endfunction

  // Expected outputs for a counter pair (R3, R4, R6)
  function automatic pos_t predict(int h, int v);
    pos_t p = '{0, 0, 0, 0, 0};
    int y, acc, n, x, off;
    bit hit = 0;
    if (v < int'(v_offset)) return p;
    y = v - int'(v_offset);
    acc = 0;
    n = 1;
    off = 0;
    for (int r = 0; r < 12; r++) begin
      int ht = 18 * row_size(r);
      if (!hit && y < acc + ht) begin
        hit = 1;
        p.row = r;
        n = row_size(r);
        off = y - acc;
      end
      acc += ht;
    end
    if (!hit) begin
      p.row = 0;
      return p;
    end
    if (h < int'(h_offset)) begin
      p.row = 0;
      return p;
    end
    x = h - int'(h_offset);
    if (x >= 288 * n) begin
      p.row = 0;
      return p;
    end
    p.inw = 1;
    p.col = x / (12 * n);
    p.dx  = (x % (12 * n)) / n;
    p.dy  = off / n;
    return p;
  endfunction

  // Bench model of the sync counters (R2) with one enabled cycle latency (R10)
  int   m_h, m_v;
  bit   m_hs, m_vs;
  pos_t e_q;

  always @(posedge clk or negedge rst_n) begin : model
    bit hl, vl;
    if (!rst_n) begin
      m_h  <= 0;
      m_v  <= 0;
      m_hs <= 0;
      m_vs <= 0;
      e_q  <= '{0, 0, 0, 0, 0};
    end else if (dot_en) begin
      hl = hsync && !m_hs;
      vl = vsync && !m_vs;
      e_q  <= predict(m_h, m_v);
      m_hs <= hsync;
      m_vs <= vsync;
      m_h  <= hl ? 0 : ((m_h < 2047) ? m_h + 1 : m_h);
      m_v  <= vl ? 0 : (hl ? ((m_v < 1023) ? m_v + 1 : m_v) : m_v);
    end
  end

  bit         prev_en;
  bit         started;
  logic [28:0] prev_out;

  task automatic fail(string req, string what, int act, int exp);
    n_fail++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  task automatic check_now();
    logic [28:0] cur;
    cur = {in_window, char_row, char_col, dot_x, dot_y, mem_addr};
    n_checks++;
    if (in_window !== e_q.inw) fail("R2 R3 R4", "in_window", int'(in_window), int'(e_q.inw));
    if (e_q.inw) begin
      if (int'(char_row) != e_q.row) fail("R5", "char_row", int'(char_row), e_q.row);
      if (int'(char_col) != e_q.col) fail("R6", "char_col", int'(char_col), e_q.col);
      if (int'(dot_x) != e_q.dx)     fail("R6", "dot_x", int'(dot_x), e_q.dx);
      if (int'(dot_y) != e_q.dy)     fail("R6", "dot_y", int'(dot_y), e_q.dy);
      if (int'(mem_addr) != e_q.row * 32 + e_q.col)
        fail("R8", "mem_addr", int'(mem_addr), e_q.row * 32 + e_q.col);
    end else begin
      n_checks++;
      if ({char_row, char_col, dot_x, dot_y, mem_addr} != '0)
        fail("R7", "coords outside", int'({char_row, char_col, dot_x, dot_y}), 0);
    end
    if (started && !prev_en) begin
      n_checks++;
      if (cur !== prev_out) fail("R9", "hold on idle", int'(cur), int'(prev_out));
    end
    prev_out = cur;
  endtask

  task automatic tick(bit hs, bit vs);
    @(negedge clk);
    check_now();
    started = 1;
    dot_en  = (($urandom % 8) != 0);
    prev_en = dot_en;
    hsync   = hs;
    vsync   = vs;
  endtask

  task automatic frame(bit tie);
    int nlines = int'(v_offset) + win_height() + 4;
    for (int ln = 0; ln < nlines; ln++) begin
      int len = (ln % 64 == 63) ? 1000 : 16 + int'($urandom % 24);
      for (int t = 0; t < len; t++) begin
        bit vs;
        vs = (ln < 3) && (tie || !(ln == 0 && t < 5));
        tick(t < 3, vs);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h1d5c_0a7e));
    rst_n = 1'b0; dot_en = 1'b0; hsync = 1'b0; vsync = 1'b0;
    v_offset = '0; h_offset = '0;
    size_a = '0; size_b = '0; size_c = '0; size_d = '0;
    started = 0; prev_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    n_checks++;
    if ({in_window, char_row, char_col, dot_x, dot_y, mem_addr} != '0)
      fail("R1", "reset outputs", int'({in_window, char_row, char_col, dot_x, dot_y}), 0);
    rst_n = 1'b1;

    // Directed: normal size, zero offsets, both syncs rise together (R2)
    frame(1'b1);
    // Directed: all triple, largest offsets (R3 R4)
    size_a = 2'b10; size_b = 2'b10; size_c = 2'b10; size_d = 2'b10;
    v_offset = 6'd63; h_offset = 6'd63;
    frame(1'b0);
    // Directed: mixed sizes with inheritance and code 11 (R5)
    size_a = 2'b01; size_b = 2'b11; size_c = 2'b10; size_d = 2'b01;
    v_offset = 6'd5; h_offset = 6'd17;
    frame(1'b0);
    // Random configurations
    for (int k = 0; k < 2; k++) begin
      size_a = 2'($urandom); size_b = 2'($urandom);
      size_c = 2'($urandom); size_d = 2'($urandom);
      v_offset = 6'($urandom); h_offset = 6'($urandom);
      frame(k[0]);
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    fail("R2", "watchdog run length", 190000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule